// File: doc/BRIEF.md
# Load Execution Unit with Paired-Word Sequencing

The block executes one load instruction at a time on behalf of an issue stage. It takes an opcode, a base register value, a signed 16-bit displacement and a destination register index. It forms the effective address and reads the containing 32-bit word over a valid/ready request port. A separate response channel returns data with an error flag. The returned word is narrowed to a byte or halfword lane where needed, and then extended with sign or zeros. The result comes back as register write commands.

A paired-word load moves two consecutive memory words into an even/odd register pair. The unit rejects an odd destination index before touching memory. It performs both reads and writes both registers in one completion cycle, and only when neither read reported an error. Every instruction ends with a one-cycle completion pulse that carries a fault code. The issue stage sees `busy_o` for the whole time an instruction is in flight.

Top module: `load_seq_unit`

## Requirements
- R1: After reset `busy_o`, `done_o`, `mem_valid_o`, `wr0_en_o` and `wr1_en_o` are all low.
- R2: While idle, a request is accepted only for opcodes 0x20 (signed byte), 0x22 (unsigned byte), 0x24 (signed halfword), 0x26 (unsigned halfword), 0x28 (word) and 0x29 (paired word). Any other opcode is ignored: no busy, no memory request, no completion.
- R3: The effective address is `base_i` plus the sign-extended 16-bit offset. `mem_addr_o` carries it with bits 1:0 cleared, and the second read of a paired load uses that word address plus 4.
- R4: Lanes are big-endian. Effective-address bits 1:0 equal to 0 select data bits 31:24, 1 selects 23:16, 2 selects 15:8 and 3 selects 7:0. A halfword with address bit 1 clear takes bits 31:16, and with it set takes bits 15:0.
- R5: Signed byte and halfword loads sign-extend to 32 bits, unsigned ones zero-extend, and a word load returns the word unchanged.
- R6: A successful paired load raises `wr0_en_o` and `wr1_en_o` in the same completion cycle. Port 0 writes index rt with the first word, and port 1 writes index rt+1 with the second word.
- R7: A paired load with an odd rt makes no memory request and completes in the cycle after acceptance with fault code 1 (alignment) and no register write.
- R8: A response with the error flag set ends the instruction with fault code 2 (memory) and no register write. An error on the first read of a paired load suppresses the second read.
- R9: `done_o` is high for exactly one cycle per accepted instruction, and `busy_o` stays high from the cycle after acceptance through that cycle. Write enables are high only in a completion cycle whose fault code is 0 (none).
- R10: At most one read is outstanding at a time. While `mem_valid_o` is high without `mem_ready_i`, both the request and its address stay unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Load request present |
| req_op_i | input | 6 | Load opcode |
| req_base_i | input | 32 | Base register value |
| req_ofs_i | input | 16 | Signed displacement |
| req_rt_i | input | 5 | Destination register index |
| busy_o | output | 1 | Instruction in flight, new requests not taken |
| mem_valid_o | output | 1 | Read request valid |
| mem_addr_o | output | 32 | Word-aligned read address |
| mem_ready_i | input | 1 | Read request taken |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 32 | Read response data |
| mem_err_i | input | 1 | Read response error |
| wr0_en_o | output | 1 | Register write port 0 enable |
| wr0_idx_o | output | 5 | Register write port 0 index |
| wr0_data_o | output | 32 | Register write port 0 data |
| wr1_en_o | output | 1 | Register write port 1 enable |
| wr1_idx_o | output | 5 | Register write port 1 index |
| wr1_data_o | output | 32 | Register write port 1 data |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 2 | Fault code at completion: 0 none, 1 alignment, 2 memory |

## Verification
The hardest situation to reach is a paired load whose second read fails after the first one succeeded. Here the first word is already captured, yet neither register may be written. The bench's memory responder returns a per-transaction error pattern indexed by beat, so a table vector can fail only the second beat. A second vector fails only the first beat, and the bench checks that exactly one read was issued. The paired sequence is also repeated with the request port alternating its ready and a longer response latency. This exercises the request-hold rule while a pair is being read.

// File: rtl/ldu_pkg.sv
package ldu_pkg;
  localparam int XLEN   = 32;
  localparam int OFS_W  = 16;
  localparam int OP_W   = 6;
  localparam int RIDX_W = 5;

  localparam logic [OP_W-1:0] OP_LDB  = 6'h20;
  localparam logic [OP_W-1:0] OP_LDBU = 6'h22;
  localparam logic [OP_W-1:0] OP_LDH  = 6'h24;
  localparam logic [OP_W-1:0] OP_LDHU = 6'h26;
  localparam logic [OP_W-1:0] OP_LDW  = 6'h28;
  localparam logic [OP_W-1:0] OP_LDP  = 6'h29;

  typedef enum logic [1:0] {FLT_NONE = 2'd0, FLT_ALIGN = 2'd1, FLT_MEM = 2'd2} fault_e;
  typedef enum logic [1:0] {ST_IDLE, ST_READ1, ST_READ2, ST_COMMIT} state_e;
  typedef enum logic [1:0] {SZ_BYTE, SZ_HALF, SZ_WORD} size_e;

  typedef struct packed {
    logic  legal;
    logic  paired;
    logic  sign;
    size_e size;
  } ld_dec_t;

  function automatic ld_dec_t decode_op(input logic [OP_W-1:0] op);
    ld_dec_t d;
    d = '{legal: 1'b1, paired: 1'b0, sign: 1'b0, size: SZ_WORD};
    case (op)
      OP_LDB:  begin d.size = SZ_BYTE; d.sign = 1'b1; end
      OP_LDBU: d.size = SZ_BYTE;
      OP_LDH:  begin d.size = SZ_HALF; d.sign = 1'b1; end
      OP_LDHU: d.size = SZ_HALF;
      OP_LDW:  d.size = SZ_WORD;
      OP_LDP:  d.paired = 1'b1;
      default: d.legal = 1'b0;
    endcase
    return d;
  endfunction
endpackage

// File: rtl/ldu_agen.sv
module ldu_agen #(
  parameter int AW = 32,
  parameter int OW = 16
) (
  input  logic [AW-1:0] base_i,
  input  logic [OW-1:0] ofs_i,
  output logic [AW-1:0] ea_o
);
  localparam int EXT_W = AW - OW;
  assign ea_o = base_i + {{EXT_W{ofs_i[OW-1]}}, ofs_i};
endmodule

// File: rtl/ldu_fmt.sv
module ldu_fmt
  import ldu_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] rdata_i,
  input  logic [1:0]    lane_i,
  input  size_e         size_i,
  input  logic          sign_i,
  output logic [DW-1:0] data_o
);
  localparam int NB = DW / 8;
  localparam int NH = DW / 16;

  logic [7:0]  byte_lane [NB];
  logic [15:0] half_lane [NH];

  // big-endian: lane 0 is the most significant byte
  for (genvar b = 0; b < NB; b++) begin : g_byte
    assign byte_lane[b] = rdata_i[DW-1-8*b -: 8];
  end
  for (genvar h = 0; h < NH; h++) begin : g_half
    assign half_lane[h] = rdata_i[DW-1-16*h -: 16];
  end

  logic [7:0]  sel_b;
  logic [15:0] sel_h;
  assign sel_b = byte_lane[lane_i];
  assign sel_h = half_lane[lane_i[1]];

  always_comb begin
    case (size_i)
      SZ_BYTE: data_o = {{(DW-8){sign_i & sel_b[7]}}, sel_b};
      SZ_HALF: data_o = {{(DW-16){sign_i & sel_h[15]}}, sel_h};
      default: data_o = rdata_i;
    endcase
  end
endmodule

// File: rtl/ldu_ctrl.sv
module ldu_ctrl
  import ldu_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32,
  parameter int RW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  input  ld_dec_t       dec_i,
  input  logic [AW-1:0] ea_i,
  input  logic [RW-1:0] rt_i,
  output logic          busy_o,
  output logic          mem_valid_o,
  output logic [AW-1:0] mem_addr_o,
  input  logic          mem_ready_i,
  input  logic          mem_rvalid_i,
  input  logic          mem_err_i,
  input  logic [DW-1:0] fmt_data_i,
  output logic [1:0]    lane_o,
  output size_e         size_o,
  output logic          sign_o,
  output logic          wr0_en_o,
  output logic [RW-1:0] wr0_idx_o,
  output logic [DW-1:0] wr0_data_o,
  output logic          wr1_en_o,
  output logic [RW-1:0] wr1_idx_o,
  output logic [DW-1:0] wr1_data_o,
  output logic          done_o,
  output fault_e        fault_o
);
  localparam int WBYTES = DW / 8;

  state_e        state_q;
  logic [AW-1:0] ea_q;
  logic [RW-1:0] rt_q;
  logic          paired_q, sign_q, issued_q;
  size_e         size_q;
  logic [DW-1:0] data0_q, data1_q;
  fault_e        fault_q;

  logic accept, in_read, beat_done;
  assign accept    = (state_q == ST_IDLE) && req_valid_i && dec_i.legal;
  assign in_read   = (state_q == ST_READ1) || (state_q == ST_READ2);
  assign beat_done = in_read && issued_q && mem_rvalid_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ea_q     <= '0;
      rt_q     <= '0;
      paired_q <= 1'b0;
      sign_q   <= 1'b0;
      size_q   <= SZ_WORD;
      issued_q <= 1'b0;
      data0_q  <= '0;
      data1_q  <= '0;
      fault_q  <= FLT_NONE;
    end else begin
      case (state_q)
        ST_IDLE: if (accept) begin
          ea_q     <= ea_i;
          rt_q     <= rt_i;
          paired_q <= dec_i.paired;
          sign_q   <= dec_i.sign;
          size_q   <= dec_i.size;
          issued_q <= 1'b0;
          if (dec_i.paired && rt_i[0]) begin
            fault_q <= FLT_ALIGN;
            state_q <= ST_COMMIT;
          end else begin
            fault_q <= FLT_NONE;
            state_q <= ST_READ1;
          end
        end
        ST_READ1, ST_READ2: begin
          if (!issued_q && mem_ready_i) issued_q <= 1'b1;
          if (beat_done) begin
            issued_q <= 1'b0;
            if (mem_err_i) begin
              fault_q <= FLT_MEM;
              state_q <= ST_COMMIT;
            end else if (state_q == ST_READ1) begin
              data0_q <= fmt_data_i;
              state_q <= paired_q ? ST_READ2 : ST_COMMIT;
            end else begin
              data1_q <= fmt_data_i;
              state_q <= ST_COMMIT;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  logic [AW-1:0] word_addr;
  assign word_addr   = {ea_q[AW-1:2], 2'b00};
  assign mem_valid_o = in_read && !issued_q;
  assign mem_addr_o  = (state_q == ST_READ2) ? word_addr + AW'(WBYTES) : word_addr;

  assign busy_o     = (state_q != ST_IDLE);
  assign done_o     = (state_q == ST_COMMIT);
  assign fault_o    = done_o ? fault_q : FLT_NONE;
  assign lane_o     = ea_q[1:0];
  assign size_o     = size_q;
  assign sign_o     = sign_q;
  assign wr0_en_o   = done_o && (fault_q == FLT_NONE);
  assign wr0_idx_o  = rt_q;
  assign wr0_data_o = data0_q;
  assign wr1_en_o   = wr0_en_o && paired_q;
  assign wr1_idx_o  = rt_q | RW'(1);
  assign wr1_data_o = data1_q;

  // R9
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  // R9
  wr_gated_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr0_en_o || wr1_en_o) |-> (done_o && fault_o == FLT_NONE));
  // R6
  pair_ports_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr1_en_o |-> (wr0_en_o && wr1_idx_o == wr0_idx_o + RW'(1)));
  // R10
  req_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o)));
  // R7
  odd_pair_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (accept && dec_i.paired && rt_i[0]) |=> (done_o && fault_o == FLT_ALIGN && !mem_valid_o));
  // R8
  mem_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (beat_done && mem_err_i) |=> (done_o && fault_o == FLT_MEM));
  // R2
  illegal_op_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && req_valid_i && !dec_i.legal) |=> !busy_o);
endmodule

// File: rtl/load_seq_unit.sv
module load_seq_unit
  import ldu_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [OP_W-1:0]   req_op_i,
  input  logic [XLEN-1:0]   req_base_i,
  input  logic [OFS_W-1:0]  req_ofs_i,
  input  logic [RIDX_W-1:0] req_rt_i,
  output logic              busy_o,
  output logic              mem_valid_o,
  output logic [XLEN-1:0]   mem_addr_o,
  input  logic              mem_ready_i,
  input  logic              mem_rvalid_i,
  input  logic [XLEN-1:0]   mem_rdata_i,
  input  logic              mem_err_i,
  output logic              wr0_en_o,
  output logic [RIDX_W-1:0] wr0_idx_o,
  output logic [XLEN-1:0]   wr0_data_o,
  output logic              wr1_en_o,
  output logic [RIDX_W-1:0] wr1_idx_o,
  output logic [XLEN-1:0]   wr1_data_o,
  output logic              done_o,
  output logic [1:0]        fault_o
);
  ld_dec_t         dec;
  logic [XLEN-1:0] ea, fmt_data;
  logic [1:0]      lane;
  size_e           size;
  logic            sign;
  fault_e          fault;

  assign dec     = decode_op(req_op_i);
  assign fault_o = fault;

  ldu_agen #(.AW(XLEN), .OW(OFS_W)) agen_i (
    .base_i (req_base_i),
    .ofs_i  (req_ofs_i),
    .ea_o   (ea)
  );

  ldu_fmt #(.DW(XLEN)) fmt_i (
    .rdata_i (mem_rdata_i),
    .lane_i  (lane),
    .size_i  (size),
    .sign_i  (sign),
    .data_o  (fmt_data)
  );

  ldu_ctrl #(.AW(XLEN), .DW(XLEN), .RW(RIDX_W)) ctrl_i (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_valid_i  (req_valid_i),
    .dec_i        (dec),
    .ea_i         (ea),
    .rt_i         (req_rt_i),
    .busy_o       (busy_o),
    .mem_valid_o  (mem_valid_o),
    .mem_addr_o   (mem_addr_o),
    .mem_ready_i  (mem_ready_i),
    .mem_rvalid_i (mem_rvalid_i),
    .mem_err_i    (mem_err_i),
    .fmt_data_i   (fmt_data),
    .lane_o       (lane),
    .size_o       (size),
    .sign_o       (sign),
    .wr0_en_o     (wr0_en_o),
    .wr0_idx_o    (wr0_idx_o),
    .wr0_data_o   (wr0_data_o),
    .wr1_en_o     (wr1_en_o),
    .wr1_idx_o    (wr1_idx_o),
    .wr1_data_o   (wr1_data_o),
    .done_o       (done_o),
    .fault_o      (fault)
  );
endmodule

// File: tb/load_seq_unit_tb_top.sv
`timescale 1ns/1ps
module load_seq_unit_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic        req_valid = 1'b0;
  logic [5:0]  req_op = '0;
  logic [31:0] req_base = '0;
  logic [15:0] req_ofs = '0;
  logic [4:0]  req_rt = '0;
  logic        busy, mem_valid, wr0_en, wr1_en, done;
  logic [31:0] mem_addr, wr0_data, wr1_data;
  logic [4:0]  wr0_idx, wr1_idx;
  logic [1:0]  fault;
  logic        mem_ready = 1'b1;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        mem_err = 1'b0;

  load_seq_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_op_i(req_op), .req_base_i(req_base),
    .req_ofs_i(req_ofs), .req_rt_i(req_rt), .busy_o(busy),
    .mem_valid_o(mem_valid), .mem_addr_o(mem_addr), .mem_ready_i(mem_ready),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata), .mem_err_i(mem_err),
    .wr0_en_o(wr0_en), .wr0_idx_o(wr0_idx), .wr0_data_o(wr0_data),
    .wr1_en_o(wr1_en), .wr1_idx_o(wr1_idx), .wr1_data_o(wr1_data),
    .done_o(done), .fault_o(fault)
  );

  typedef struct packed {
    logic [5:0]  op;
    logic [31:0] base;
    logic [15:0] ofs;
    logic [4:0]  rt;
    logic [31:0] w0;
    logic [31:0] w1;
    logic        e0;
    logic        e1;
    logic [1:0]  flt;
    logic [31:0] d0;
    logic [31:0] d1;
    logic [1:0]  nrd;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{6'h20, 32'h1000, 16'h0001, 5'd3,  32'h11853344, 32'h0, 1'b0, 1'b0, 2'd0, 32'hFFFFFF85, 32'h0, 2'd1},
    '{6'h22, 32'h1000, 16'h0001, 5'd3,  32'h11853344, 32'h0, 1'b0, 1'b0, 2'd0, 32'h00000085, 32'h0, 2'd1},
    '{6'h20, 32'h2000, 16'h0000, 5'd1,  32'h7F000000, 32'h0, 1'b0, 1'b0, 2'd0, 32'h0000007F, 32'h0, 2'd1},
    '{6'h24, 32'h3000, 16'h0002, 5'd9,  32'h12348001, 32'h0, 1'b0, 1'b0, 2'd0, 32'hFFFF8001, 32'h0, 2'd1},
    '{6'h26, 32'h3000, 16'h0000, 5'd9,  32'hC0DE0000, 32'h0, 1'b0, 1'b0, 2'd0, 32'h0000C0DE, 32'h0, 2'd1},
    '{6'h28, 32'h1010, 16'hFFF0, 5'd12, 32'hCAFEF00D, 32'h0, 1'b0, 1'b0, 2'd0, 32'hCAFEF00D, 32'h0, 2'd1},
    '{6'h29, 32'h4000, 16'h0008, 5'd4,  32'hAAAA5555, 32'h01234567, 1'b0, 1'b0, 2'd0, 32'hAAAA5555, 32'h01234567, 2'd2},
    '{6'h29, 32'h8000, 16'h0000, 5'd7,  32'h1, 32'h2, 1'b0, 1'b0, 2'd1, 32'h0, 32'h0, 2'd0},
    '{6'h28, 32'h7000, 16'h0004, 5'd5,  32'h55555555, 32'h0, 1'b1, 1'b0, 2'd2, 32'h0, 32'h0, 2'd1},
    '{6'h29, 32'h6000, 16'h0000, 5'd2,  32'h11111111, 32'h22222222, 1'b0, 1'b1, 2'd2, 32'h0, 32'h0, 2'd2},
    '{6'h29, 32'h6100, 16'h0000, 5'd6,  32'h11111111, 32'h22222222, 1'b1, 1'b0, 2'd2, 32'h0, 32'h0, 2'd1},
    '{6'h20, 32'h5004, 16'hFFFF, 5'd8,  32'h000000F0, 32'h0, 1'b0, 1'b0, 2'd0, 32'hFFFFFFF0, 32'h0, 2'd1}
  };

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder
  bit          stall_mode = 1'b0;
  int          lat = 1;
  int          hs_cnt = 0;
  logic [31:0] hs_addr [2];
  logic [31:0] cur_w0, cur_w1;
  logic        cur_e0, cur_e1;
  int          pend_cnt = 0;
  logic [31:0] pend_data = '0;
  logic        pend_err = 1'b0;

  initial begin
    forever begin
      @(negedge clk);
      if (mem_rvalid) begin
        mem_rvalid = 1'b0;
        mem_err = 1'b0;
      end
      if (pend_cnt > 0) begin
        pend_cnt--;
        if (pend_cnt == 0) begin
          mem_rvalid = 1'b1;
          mem_rdata = pend_data;
          mem_err = pend_err;
        end
      end
      mem_ready = stall_mode ? ~mem_ready : 1'b1;
      if (mem_valid && mem_ready) begin
        if (hs_cnt < 2) hs_addr[hs_cnt] = mem_addr;
        pend_data = (hs_cnt == 0) ? cur_w0 : cur_w1;
        pend_err = (hs_cnt == 0) ? cur_e0 : cur_e1;
        hs_cnt++;
        pend_cnt = lat;
      end
    end
  end

  task automatic run_vec(input vec_t v);
    logic [31:0] ea;
    int waits;
    cur_w0 = v.w0; cur_w1 = v.w1; cur_e0 = v.e0; cur_e1 = v.e1;
    hs_cnt = 0;
    ea = v.base + {{16{v.ofs[15]}}, v.ofs};
    @(negedge clk);
    req_valid = 1'b1; req_op = v.op; req_base = v.base; req_ofs = v.ofs; req_rt = v.rt;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R9 busy after accept", 32'(busy), 32'd1);
    waits = 0;
    while (!done && waits < 200) begin
      @(negedge clk);
      waits++;
    end
    if (!done) begin
      errors++;
      $display("FAIL R9 completion timeout actual=0 expected=1");
    end
    chk("R7/R8 fault code", 32'(fault), 32'(v.flt));
    chk("R9 busy at done", 32'(busy), 32'd1);
    chk("R9 wr0 enable", 32'(wr0_en), 32'(v.flt == 2'd0));
    chk("R6 wr1 enable", 32'(wr1_en), 32'(v.flt == 2'd0 && v.op == 6'h29));
    if (v.flt == 2'd0) begin
      chk("R4/R5 wr0 data", wr0_data, v.d0);
      chk("R6 wr0 index", 32'(wr0_idx), 32'(v.rt));
      if (v.op == 6'h29) begin
        chk("R6 wr1 data", wr1_data, v.d1);
        chk("R6 wr1 index", 32'(wr1_idx), 32'(v.rt) + 1);
      end
    end
    if (v.flt == 2'd1) chk("R7 latency", 32'(waits), 32'd0);
    chk("R8 read count", 32'(hs_cnt), 32'(v.nrd));
    if (v.nrd > 0) chk("R3 first address", hs_addr[0], {ea[31:2], 2'b00});
    if (v.nrd > 1) chk("R3 second address", hs_addr[1], {ea[31:2], 2'b00} + 32'd4);
    @(negedge clk);
    chk("R9 done one cycle", 32'(done), 32'd0);
    chk("R9 no write after done", 32'(wr0_en | wr1_en), 32'd0);
    chk("R9 idle after done", 32'(busy), 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #1;
    // R1
    chk("R1 busy in reset", 32'(busy), 32'd0);
    chk("R1 done in reset", 32'(done), 32'd0);
    chk("R1 mem_valid in reset", 32'(mem_valid), 32'd0);
    chk("R1 write enables in reset", 32'(wr0_en | wr1_en), 32'd0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", 32'(busy), 32'd0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i]);

    // R10: paired load with stalled request port and longer latency
    stall_mode = 1'b1;
    lat = 3;
    run_vec(VECS[6]);
    run_vec(VECS[9]);
    stall_mode = 1'b0;
    lat = 1;

    // R2: illegal opcodes ignored
    for (int k = 0; k < 3; k++) begin
      hs_cnt = 0;
      @(negedge clk);
      req_valid = 1'b1;
      req_op = (k == 0) ? 6'h21 : (k == 1) ? 6'h2A : 6'h00;
      req_base = 32'h9000; req_ofs = '0; req_rt = 5'd2;
      @(negedge clk);
      req_valid = 1'b0;
      chk("R2 illegal op not busy", 32'(busy), 32'd0);
      repeat (3) @(negedge clk);
      chk("R2 illegal op no read", 32'(hs_cnt), 32'd0);
      chk("R2 illegal op no done", 32'(done), 32'd0);
    end

    // R1: reset in the middle of a paired load
    cur_w0 = 32'h1; cur_w1 = 32'h2; cur_e0 = 1'b0; cur_e1 = 1'b0; hs_cnt = 0;
    lat = 4;
    @(negedge clk);
    req_valid = 1'b1; req_op = 6'h29; req_base = 32'hA000; req_ofs = '0; req_rt = 5'd10;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("R1 busy cleared by reset", 32'(busy), 32'd0);
    chk("R1 request cleared by reset", 32'(mem_valid), 32'd0);
    repeat (6) @(negedge clk);
    rst_n = 1'b1;
    lat = 1;
    @(negedge clk);
    chk("R1 no done after reset", 32'(done), 32'd0);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule